// File: doc/BRIEF.md
# Serial NOR Flash Command and Read Front-End

This block is the device side of a serial flash interface, modelled so that it can be synthesised. Chip select, serial clock and serial data in are brought into the system clock domain, and their edges are found there. Each frame is then decoded as an 8-bit opcode, a 24-bit address and as many dummy bytes as the opcode needs. The three single-lane array-read opcodes read bytes from a small pattern memory through an address pointer that increments after each byte. Those bytes leave MSB first on the falling edges of the serial clock. The output enable is high only while the frame is in its data phase.

All other recognised opcodes are handed to neighbouring blocks as a strobe that lasts one system clock and carries the opcode and the 22-bit address. Opcodes without an address are handed over as soon as their eighth bit arrives. Opcodes with an address are handed over after the 24th address bit. An opcode the block does not know makes it deaf until chip select goes high and then low again. A frame cut short before its header is complete does nothing.

The controller is a six-state machine. IDLE holds while deselected, and IDLE→OPCODE happens once chip select goes low. OPCODE→ADDR is taken for a read or an addressed opcode. OPCODE→DEAF is taken for an opcode with no address (with a strobe) or for an unknown opcode (with no strobe). ADDR→DUMMY is taken for a read that needs dummy bytes, and ADDR→DATA for one that needs none. ADDR→DEAF is taken for an addressed non-read opcode, with a strobe. DUMMY→DATA follows the last dummy byte. Every state returns to IDLE when chip select goes high.

Top module: `flash_spi_frontend`

## Requirements
- R1: From reset, and from the system clock after chip select goes high, spi_miso_oe is 0, spi_miso is 0 and cmd_valid is 0. spi_miso_oe is never 1 outside the data phase.
- R2: Opcode 03h is followed by 3 address bytes and no dummy byte. On the falling serial clock edge after the 32nd rising edge, the MSB of the byte at the start address appears on spi_miso. The byte stored at address a is ((a mod MEM_DEPTH)·37 + 11) mod 256.
- R3: Opcode 0Bh reads the same data as 03h, but it takes 1 dummy byte after the address, so data starts after the 40th rising edge.
- R4: Opcode 1Bh takes 2 dummy bytes after the address, so data starts after the 48th rising edge.
- R5: While chip select stays low, reading continues with consecutive bytes at increasing addresses and no gap between them.
- R6: Address bits 23 and 22 are ignored. After address 3FFFFFh the read continues at 000000h without delay.
- R7: An unknown opcode produces no strobe and no output. All further bits are ignored until chip select is deasserted and asserted again, and after that a new opcode is accepted normally.
- R8: If chip select rises before the opcode and any address it requires are complete, the frame produces no strobe and no output.
- R9: The opcodes 06h, 04h, 60h, C7h, B0h, D0h, 05h, 3Fh, 9Fh, B9h, ABh, F0h, 01h, 31h and 3Eh raise the strobe after their 8th bit, with cmd_addr equal to 0.
- R10: The opcodes 20h, 52h, D8h, 02h, A2h, 32h, 36h, 39h, 3Ch, 33h, 34h, 35h, 9Bh, 77h, 3Bh and 6Bh raise the strobe after the 24th address bit. cmd_addr carries the address with bits 23:22 cleared. Later bits in the same frame raise no second strobe.
- R11: cmd_valid is high for exactly one system clock per decoded command.
- R12: spi_miso changes only after a falling serial clock edge or a deselect. spi_miso_oe rises on the first falling edge in the data phase. A read may stop in the middle of a byte.
- R13: Mode 3, in which the serial clock idles high, gives the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low reset, asynchronous |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 or mode 3 |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| cmd_valid | output | 1 | Strobe for a decoded command, one cycle |
| cmd_opcode | output | 8 | Opcode of the decoded command |
| cmd_addr | output | 24 | Address of the decoded command, bits 23:22 zero |

## Verification
The checker looks at every cycle for the following. The output bit and its enable must stay quiet while the block is deselected. spi_miso may change only after a falling serial clock edge or a deselect, and the enable may rise only on such an edge during the data phase. Each strobe must be a single-cycle pulse with the top two address bits clear. The bench scenarios are the only place that can show the rest. They show which byte is read and at which bit position the data starts for each dummy count. They also cover the address wrap and masking, deafness after an unknown opcode, aborted headers, the exact strobe timing for each opcode class, and mode 3.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_DEAF
    } fe_state_t;

    localparam logic [7:0] OPC_RD_PLAIN = 8'h03;
    localparam logic [7:0] OPC_RD_ONE   = 8'h0B;
    localparam logic [7:0] OPC_RD_TWO   = 8'h1B;

    function automatic logic is_array_read(input logic [7:0] opc);
        return (opc == OPC_RD_PLAIN) || (opc == OPC_RD_ONE) || (opc == OPC_RD_TWO);
    endfunction

    function automatic logic [1:0] dummy_count(input logic [7:0] opc);
        case (opc)
            OPC_RD_TWO: return 2'd2;
            OPC_RD_ONE: return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction

    function automatic logic is_bare_cmd(input logic [7:0] opc);
        case (opc)
            8'h06, 8'h04, 8'h60, 8'hC7, 8'hB0, 8'hD0, 8'h05, 8'h3F,
            8'h9F, 8'hB9, 8'hAB, 8'hF0, 8'h01, 8'h31, 8'h3E: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_addr_cmd(input logic [7:0] opc);
        case (opc)
            8'h20, 8'h52, 8'hD8, 8'h02, 8'hA2, 8'h32, 8'h36, 8'h39,
            8'h3C, 8'h33, 8'h34, 8'h35, 8'h9B, 8'h77, 8'h3B, 8'h6B: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] fill_byte(input int unsigned idx);
        int unsigned v;
        v = (idx * 37 + 11) % 256;
        return v[7:0];
    endfunction

endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sck_in,
    input  logic si_in,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [STAGES-1:0] cs_q;
    logic [STAGES:0]   sck_q;
    logic [STAGES-1:0] si_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '1;
            sck_q <= '0;
            si_q  <= '0;
        end else begin
            cs_q  <= {cs_q[STAGES-2:0], cs_n_in};
            sck_q <= {sck_q[STAGES-1:0], sck_in};
            si_q  <= {si_q[STAGES-2:0], si_in};
        end
    end

    assign sel      = ~cs_q[STAGES-1];
    assign sck_rise =  sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall = ~sck_q[STAGES-1] &  sck_q[STAGES];
    assign si_s     =  si_q[STAGES-1];
endmodule

// File: rtl/fe_rx_shift.sv
module fe_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       take,
    input  logic       bit_in,
    output logic [7:0] rx_byte,
    output logic       rx_done
);
    logic [2:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            bit_cnt <= '0;
            rx_done <= 1'b0;
        end else if (clear) begin
            bit_cnt <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (take) begin
                rx_byte <= {rx_byte[6:0], bit_in};
                bit_cnt <= bit_cnt + 3'd1;
                rx_done <= (bit_cnt == 3'd7);
            end
        end
    end
endmodule

// File: rtl/fe_read_mem.sv
module fe_read_mem #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        load,
    input  logic [21:0] load_addr,
    input  logic        shift,
    output logic        bit_out
);
    import flash_fe_pkg::*;

    logic [7:0]  mem [DEPTH];
    logic [21:0] ptr;
    logic [7:0]  tx_sh;
    logic [2:0]  out_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= fill_byte(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr     <= '0;
            tx_sh   <= '0;
            out_cnt <= '0;
            bit_out <= 1'b0;
        end else if (clear) begin
            out_cnt <= '0;
            bit_out <= 1'b0;
        end else if (load) begin
            tx_sh   <= mem[load_addr[AW-1:0]];
            ptr     <= load_addr + 22'd1;
            out_cnt <= '0;
        end else if (shift) begin
            bit_out <= tx_sh[7];
            out_cnt <= out_cnt + 3'd1;
            if (out_cnt == 3'd7) begin
                tx_sh <= mem[ptr[AW-1:0]];
                ptr   <= ptr + 22'd1;
            end else begin
                tx_sh <= {tx_sh[6:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/flash_spi_frontend.sv
module flash_spi_frontend #(
    parameter int MEM_DEPTH   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        spi_miso_oe,
    output logic        cmd_valid,
    output logic [7:0]  cmd_opcode,
    output logic [23:0] cmd_addr
);
    import flash_fe_pkg::*;

    fe_state_t   state_q, state_d;
    logic        sel, sck_rise, sck_fall, si_s;
    logic [7:0]  rx_byte;
    logic        rx_done;
    logic [1:0]  byte_idx;
    logic [7:0]  opc_q;
    logic [21:0] addr_q;
    logic [21:0] addr_full;
    logic        hdr_phase;
    logic        in_data;
    logic        mem_load;
    logic [21:0] mem_load_addr;
    logic        oe_q;

    fe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_in  (spi_cs_n),
        .sck_in   (spi_sck),
        .si_in    (spi_mosi),
        .sel      (sel),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_s     (si_s)
    );

    assign hdr_phase = (state_q == ST_OPCODE) || (state_q == ST_ADDR) || (state_q == ST_DUMMY);
    assign in_data   = (state_q == ST_DATA);

    fe_rx_shift u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (~sel),
        .take    (sck_rise & hdr_phase),
        .bit_in  (si_s),
        .rx_byte (rx_byte),
        .rx_done (rx_done)
    );

    assign addr_full = {addr_q[13:0], rx_byte};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (rx_done) begin
                    if (is_array_read(rx_byte) || is_addr_cmd(rx_byte)) state_d = ST_ADDR;
                    else                                                 state_d = ST_DEAF;
                end
                ST_ADDR:   if (rx_done && byte_idx == 2'd2) begin
                    if (!is_array_read(opc_q))          state_d = ST_DEAF;
                    else if (dummy_count(opc_q) == 2'd0) state_d = ST_DATA;
                    else                                 state_d = ST_DUMMY;
                end
                ST_DUMMY:  if (rx_done && byte_idx == 2'(dummy_count(opc_q) - 2'd1)) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_DEAF:   state_d = ST_DEAF;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    assign mem_load = sel && (state_d == ST_DATA) && (state_q != ST_DATA);
    assign mem_load_addr = (state_q == ST_ADDR) ? addr_full : addr_q;

    // outputs and header registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx   <= '0;
            opc_q      <= '0;
            addr_q     <= '0;
            oe_q       <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_opcode <= '0;
            cmd_addr   <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (!sel) begin
                byte_idx <= '0;
                oe_q     <= 1'b0;
            end else begin
                if (in_data && sck_fall) oe_q <= 1'b1;
                if (rx_done) begin
                    unique case (state_q)
                        ST_OPCODE: begin
                            opc_q    <= rx_byte;
                            byte_idx <= '0;
                            if (is_bare_cmd(rx_byte)) begin
                                cmd_valid  <= 1'b1;
                                cmd_opcode <= rx_byte;
                                cmd_addr   <= '0;
                            end
                        end
                        ST_ADDR: begin
                            addr_q <= addr_full;
                            if (byte_idx == 2'd2) begin
                                byte_idx <= '0;
                                if (!is_array_read(opc_q)) begin
                                    cmd_valid  <= 1'b1;
                                    cmd_opcode <= opc_q;
                                    cmd_addr   <= {2'b00, addr_full};
                                end
                            end else begin
                                byte_idx <= byte_idx + 2'd1;
                            end
                        end
                        ST_DUMMY: byte_idx <= byte_idx + 2'd1;
                        default: ;
                    endcase
                end
            end
        end
    end

    fe_read_mem #(.DEPTH(MEM_DEPTH)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (~sel),
        .load      (mem_load),
        .load_addr (mem_load_addr),
        .shift     (in_data & sck_fall),
        .bit_out   (spi_miso)
    );

    assign spi_miso_oe = oe_q;
endmodule

// File: rtl/flash_fe_checker.sv
module flash_fe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        sck_fall,
    input logic        in_data,
    input logic        miso,
    input logic        miso_oe,
    input logic        cmd_valid,
    input logic [23:0] cmd_addr
);
    // R1
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!miso_oe && !miso));

    // R1
    oe_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> in_data);

    // R12
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> $past(sck_fall && in_data));

    // R12
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_fall) || $past(!sel)));

    // R11
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R10
    strobe_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_addr[23:22] == 2'b00));
endmodule

bind flash_spi_frontend flash_fe_checker u_fe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .sck_fall  (sck_fall),
    .in_data   (in_data),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr)
);

// File: tb/flash_spi_frontend_test.sv
module flash_spi_frontend_test;
    localparam int DEPTH = 64;
    localparam int HALF  = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        miso, miso_oe, cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int oe_cycles = 0;
    int cycles = 0;
    bit done = 1'b0;
    logic [7:0]  last_opc = '0;
    logic [23:0] last_addr = '0;

    always #4 clk = ~clk;

    flash_spi_frontend #(.MEM_DEPTH(DEPTH)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (cs_n),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .cmd_valid   (cmd_valid),
        .cmd_opcode  (cmd_opcode),
        .cmd_addr    (cmd_addr)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cmd_valid) begin
            strobes   <= strobes + 1;
            last_opc  <= cmd_opcode;
            last_addr <= cmd_addr;
        end
        if (miso_oe) oe_cycles <= oe_cycles + 1;
    end

    always @(posedge clk) begin
        if (cycles == 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        int unsigned i;
        i = a % DEPTH;
        return 8'((i * 37 + 11) % 256);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_frame(input bit mode3);
        @(negedge clk);
        sck = mode3;
        wait_clk(2 * HALF);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic end_frame(input bit mode3);
        if (!mode3) begin
            sck = 1'b0;
            wait_clk(HALF);
        end
        cs_n = 1'b1;
        wait_clk(4 * HALF);
    endtask

    task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - nbits; b--) begin
            sck  = 1'b0;
            mosi = tx[b];
            wait_clk(HALF);
            rx[b] = miso;
            sck  = 1'b1;
            wait_clk(HALF);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        xfer_bits(tx, 8, rx);
    endtask

    task automatic send_header(input logic [7:0] opc, input logic [23:0] a, input int ndummy);
        logic [7:0] junk;
        xfer(opc, junk);
        xfer(a[23:16], junk);
        xfer(a[15:8], junk);
        xfer(a[7:0], junk);
        for (int d = 0; d < ndummy; d++) xfer(8'hA5, junk);
    endtask

    task automatic read_and_check(input logic [7:0] opc, input logic [23:0] a, input int ndummy,
                                  input int nbytes, input bit mode3, input string req);
        logic [7:0] rx;
        int oe0;
        begin_frame(mode3);
        send_header(opc, a, ndummy);
        oe0 = oe_cycles;
        for (int k = 0; k < nbytes; k++) begin
            xfer(8'h00, rx);
            check(rx == exp_byte(24'(a + k)), req, rx, exp_byte(24'(a + k)));
        end
        check(oe_cycles > oe0, req, oe_cycles - oe0, 1);
        end_frame(mode3);
        check(miso_oe == 1'b0 && miso == 1'b0, "R1", {miso_oe, miso}, 0);
    endtask

    task automatic t_reset;
        check(miso_oe == 1'b0, "R1", miso_oe, 0);
        check(miso == 1'b0, "R1", miso, 0);
        check(cmd_valid == 1'b0, "R1", cmd_valid, 0);
    endtask

    task automatic t_read_plain;  read_and_check(8'h03, 24'h000005, 0, 3, 1'b0, "R2"); endtask
    task automatic t_read_one;    read_and_check(8'h0B, 24'h000010, 1, 2, 1'b0, "R3"); endtask
    task automatic t_read_two;    read_and_check(8'h1B, 24'h00003E, 2, 3, 1'b0, "R4 R5"); endtask
    task automatic t_sequential;  read_and_check(8'h03, 24'h000100, 0, 6, 1'b0, "R5"); endtask
    task automatic t_wrap;        read_and_check(8'h03, 24'h3FFFFE, 0, 3, 1'b0, "R6"); endtask
    task automatic t_mode3;       read_and_check(8'h0B, 24'h000020, 1, 2, 1'b1, "R13"); endtask

    task automatic t_high_bits;
        logic [7:0] rx;
        begin_frame(1'b0);
        send_header(8'h03, 24'hC00009, 0);
        xfer(8'h00, rx);
        check(rx == exp_byte(24'h000009), "R6", rx, exp_byte(24'h000009));
        end_frame(1'b0);
    endtask

    task automatic t_unknown;
        logic [7:0] rx;
        int s0, o0;
        s0 = strobes; o0 = oe_cycles;
        begin_frame(1'b0);
        xfer(8'hFF, rx);
        xfer(8'h06, rx);
        xfer(8'h03, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        end_frame(1'b0);
        check(strobes == s0, "R7", strobes - s0, 0);
        check(oe_cycles == o0, "R7", oe_cycles - o0, 0);
        begin_frame(1'b0);
        xfer(8'h06, rx);
        end_frame(1'b0);
        check(strobes == s0 + 1 && last_opc == 8'h06, "R7", last_opc, 8'h06);
    endtask

    task automatic t_abort;
        logic [7:0] rx;
        int s0, o0;
        s0 = strobes; o0 = oe_cycles;
        begin_frame(1'b0);
        xfer(8'h03, rx);
        xfer(8'h00, rx);
        xfer(8'h01, rx);
        end_frame(1'b0);
        begin_frame(1'b0);
        xfer(8'h20, rx);
        xfer(8'h01, rx);
        xfer(8'h02, rx);
        xfer_bits(8'h03, 5, rx);
        end_frame(1'b0);
        begin_frame(1'b0);
        xfer_bits(8'h06, 6, rx);
        end_frame(1'b0);
        check(strobes == s0, "R8", strobes - s0, 0);
        check(oe_cycles == o0, "R8", oe_cycles - o0, 0);
        read_and_check(8'h03, 24'h000007, 0, 1, 1'b0, "R8");
    endtask

    task automatic t_bare_cmds;
        logic [7:0] rx;
        logic [7:0] list [3] = '{8'h9F, 8'hC7, 8'h3E};
        for (int i = 0; i < 3; i++) begin
            int s0;
            s0 = strobes;
            begin_frame(1'b0);
            xfer(list[i], rx);
            wait_clk(6);
            check(strobes == s0 + 1, "R9 R11", strobes - s0, 1);
            check(last_opc == list[i] && last_addr == 24'h0, "R9", {last_opc, last_addr}, {list[i], 24'h0});
            xfer(8'h55, rx);
            end_frame(1'b0);
        end
    endtask

    task automatic t_addr_cmd;
        logic [7:0] rx;
        int s0;
        s0 = strobes;
        begin_frame(1'b0);
        send_header(8'h20, 24'hC12345, 0);
        wait_clk(6);
        check(strobes == s0 + 1, "R10 R11", strobes - s0, 1);
        check(last_opc == 8'h20 && last_addr == 24'h012345, "R10", {last_opc, last_addr}, {8'h20, 24'h012345});
        xfer(8'h06, rx);
        xfer(8'hD8, rx);
        end_frame(1'b0);
        check(strobes == s0 + 1, "R10", strobes - s0, 1);
    endtask

    task automatic t_stop_mid;
        logic [7:0] rx;
        logic [7:0] e;
        e = exp_byte(24'h000002);
        begin_frame(1'b0);
        send_header(8'h03, 24'h000001, 0);
        xfer(8'h00, rx);
        xfer_bits(8'h00, 3, rx);
        check(rx[7:5] == e[7:5], "R12", rx[7:5], e[7:5]);
        check(miso_oe == 1'b1, "R12", miso_oe, 1);
        end_frame(1'b0);
        check(miso_oe == 1'b0 && miso == 1'b0, "R12", {miso_oe, miso}, 0);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_read_plain();
        t_read_one();
        t_read_two();
        t_sequential();
        t_wrap();
        t_high_bits();
        t_unknown();
        t_abort();
        t_bare_cmds();
        t_addr_cmd();
        t_stop_mid();
        t_mode3();
        t_read_plain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule